// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Clear-to-Send Flow Control

This block reads payload bytes from an external first-word-fall-through byte queue and turns them into an HDLC bit stream, one line bit per clock. Each frame opens and closes with the 0x7E flag. A zero is stuffed after any five consecutive ones in the payload and the check sequence. A 16-bit frame check sequence follows the payload unless the caller disables it. While nothing is being sent, the line holds a steady run of ones. The block can optionally send a programmable training byte a chosen number of times ahead of the opening flag, so that a far-end phase-locked loop can lock before the frame.

Flow control follows an active-low clear-to-send input. While transmission is enabled and that input is inactive, the line drops to mark idle. What happens to the frame in progress depends on the auto mode. With the mode off, the frame is frozen and resumes where it stopped. With the mode on, the block resets to idle and raises a flush request, which the byte queue uses to empty itself. A separate control bit drives an active-low data-terminal-ready output.

Top module: `hdlc_tx_flow`

## Requirements
- R1: During and right after reset, `tx_bit` is 1, `dtr_n` is 1 and `fifo_pop` is 0.
- R2: `dtr_n` equals the inverse of `dtr_req`, delayed by one clock.
- R3: While `tx_en` is 0, or the queue is empty in idle, `tx_bit` is 1 on every cycle. `fifo_pop` stays 0 while `tx_en` is 0.
- R4: A frame starts when `tx_en` is 1, `cts_n` is 0 and the queue is not empty. It opens and closes with the flag byte 0x7E. Every byte goes out least significant bit first, so the flag's bits in time order are 0,1,1,1,1,1,1,0.
- R5: Inside the payload and the check sequence, a 0 is inserted after every five consecutive 1s. This includes a run that ends at the last check-sequence bit, where the 0 comes before the closing flag. Preamble and flag bits are never stuffed.
- R6: The check sequence is the bit-reflected CRC-16 with generator x^16+x^12+x^5+1 (0x8408 in reflected form). It is preset to 0xFFFF and run over the payload bits. It is sent one's-complemented, low byte first, each byte least significant bit first.
- R7: With `no_crc` at 1 when the last payload byte finishes, no check sequence is sent, and the closing flag follows the payload directly.
- R8: With `pre_en` at 1, `dma_mode` at 0 and `pre_count` N above 0, the byte `pre_byte` is sent N times, unstuffed and least significant bit first, between idle and the opening flag. With N at 0, no preamble is sent.
- R9: With `dma_mode` at 1, `pre_en` has no effect, and the frame opens straight after idle.
- R10: With `auto_en` at 0, `tx_en` at 1 and `cts_n` at 1, `tx_bit` is 1, no byte is popped and `fifo_flush` stays 0. The frame then continues without loss once `cts_n` returns to 0.
- R11: With `auto_en` at 1, `tx_en` at 1 and `cts_n` at 1, `tx_bit` is 1 and `fifo_flush` is 1 on every such cycle. The transmitter returns to idle, so no stale frame continues after `cts_n` returns to 0.
- R12: With `tx_en` at 0, `cts_n` has no effect: `fifo_flush` stays 0 and queued bytes are kept.
- R13: The payload ends after a byte whose `fifo_last` flag was 1, or after any byte at whose end the queue is empty. `fifo_pop` is only asserted while `fifo_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| dma_mode | input | 1 | Block-transfer mode; disables the preamble |
| pre_en | input | 1 | Preamble enable |
| pre_byte | input | 8 | Preamble byte pattern |
| pre_count | input | PRE_CNT_W | Number of preamble bytes |
| no_crc | input | 1 | Omit the check sequence |
| auto_en | input | 1 | Clear-to-send loss flushes and resets when 1 |
| dtr_req | input | 1 | Data-terminal-ready request |
| cts_n | input | 1 | Clear to send, active low |
| fifo_empty | input | 1 | Byte queue empty |
| fifo_data | input | 8 | Head byte of the queue |
| fifo_last | input | 1 | Head byte ends its frame |
| fifo_pop | output | 1 | Consume the head byte at this clock edge |
| fifo_flush | output | 1 | Request to empty the byte queue |
| dtr_n | output | 1 | Data terminal ready, active low |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench decodes the line on its own, removing stuffed zeros and finding flags. It uses payloads full of ones, such as 0xFF and 0x7E. A design that stuffs at the wrong run length, or forgets the zero at a byte boundary, yields a corrupted payload or a false flag. Preamble tests compare the repetition count directly. A counter off by one shows up as one byte too many or too few, and with the block-transfer input set the count must be zero. The two clear-to-send tests drop the input mid-frame. A frozen frame must resume bit-exact. In auto mode, a design that kept its state or did not flush would send leftover bytes after the input returns.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PRE   = 3'd1,
    S_OFLAG = 3'd2,
    S_DATA  = 3'd3,
    S_FCS   = 3'd4,
    S_CFLAG = 3'd5
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] FCS_PRESET = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_R = 16'h8408;
  localparam int          FCS_BITS   = 16;

  // one bit of the reflected CRC-16 recursion
  function automatic logic [15:0] fcs_next(input logic [15:0] cur, input logic din);
    logic fb;
    fb = cur[0] ^ din;
    fcs_next = (cur >> 1) ^ (fb ? FCS_POLY_R : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic absorb,
  input  logic din,
  input  logic drain,
  output logic fcs_bit
);
  logic [FCS_BITS-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= FCS_PRESET;
    else if (preset) acc_q <= FCS_PRESET;
    else if (absorb) acc_q <= fcs_next(acc_q, din);
    else if (drain)  acc_q <= {1'b1, acc_q[FCS_BITS-1:1]};
  end

  assign fcs_bit = ~acc_q[0];
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic stuff_due
);
  localparam int RW = $clog2(RUN_MAX + 1);
  logic [RW-1:0] run_q;

  assign stuff_due = (run_q == RW'(RUN_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= '0;
    else if (clr)       run_q <= '0;
    else if (step) begin
      if (stuff_due)    run_q <= '0;
      else if (bit_in)  run_q <= run_q + RW'(1);
      else              run_q <= '0;
    end
  end
endmodule

// File: rtl/hdlc_tx_flow.sv
module hdlc_tx_flow
  import hdlc_tx_pkg::*;
#(
  parameter int PRE_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 dma_mode,
  input  logic                 pre_en,
  input  logic [7:0]           pre_byte,
  input  logic [PRE_CNT_W-1:0] pre_count,
  input  logic                 no_crc,
  input  logic                 auto_en,
  input  logic                 dtr_req,
  input  logic                 cts_n,
  input  logic                 fifo_empty,
  input  logic [7:0]           fifo_data,
  input  logic                 fifo_last,
  output logic                 fifo_pop,
  output logic                 fifo_flush,
  output logic                 dtr_n,
  output logic                 tx_bit
);
  localparam int CNT_W = $clog2(FCS_BITS);

  tx_state_e            st, st_n;
  logic [CNT_W-1:0]     cnt, cnt_n;
  logic [7:0]           sh, sh_n;
  logic                 last_q, last_n;
  logic [PRE_CNT_W-1:0] rep, rep_n;

  // named events
  logic ev_run, ev_hold, ev_kill, st_idle, st_pre;
  logic [2:0] st_code;
  logic pre_on, stuff_due, stuff_ins, stuff_step, stuff_clr, advance;
  logic byte_end, fcs_end, fcs_bit, cur_bit, pay_done;

  assign ev_run  = tx_en & ~cts_n;
  assign ev_hold = tx_en & cts_n & ~auto_en;
  assign ev_kill = ~tx_en | (cts_n & auto_en);
  assign st_idle = (st == S_IDLE);
  assign st_pre  = (st == S_PRE);
  assign st_code = st;

  assign pre_on   = pre_en & ~dma_mode & (pre_count != '0);
  assign byte_end = (cnt == CNT_W'(7));
  assign fcs_end  = (cnt == CNT_W'(FCS_BITS - 1));

  assign stuff_ins  = ev_run & stuff_due &
                      (st == S_DATA || st == S_FCS || st == S_CFLAG);
  assign stuff_step = ev_run & ((st == S_DATA) || (st == S_FCS) ||
                                (st == S_CFLAG && stuff_due));
  assign stuff_clr  = ev_kill | (st == S_IDLE) | (st == S_PRE) | (st == S_OFLAG);
  assign advance    = ev_run & ~stuff_ins;

  always_comb begin
    unique case (st)
      S_PRE:           cur_bit = sh[0];
      S_OFLAG, S_CFLAG: cur_bit = stuff_ins ? 1'b0 : FLAG_BYTE[cnt[2:0]];
      S_DATA:          cur_bit = stuff_ins ? 1'b0 : sh[0];
      S_FCS:           cur_bit = stuff_ins ? 1'b0 : fcs_bit;
      default:         cur_bit = 1'b1;
    endcase
  end

  // payload ends after a marked byte or when the queue runs dry
  assign pay_done = last_q | fifo_empty;
  assign fifo_pop = advance & byte_end & ~fifo_empty &
                    ((st == S_OFLAG) || (st == S_DATA && !last_q));
  assign fifo_flush = tx_en & cts_n & auto_en;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; last_n = last_q; rep_n = rep;
    if (advance) begin
      unique case (st)
        S_IDLE: if (!fifo_empty) begin
          cnt_n = '0;
          if (pre_on) begin
            st_n = S_PRE; sh_n = pre_byte; rep_n = pre_count;
          end else begin
            st_n = S_OFLAG;
          end
        end
        S_PRE: begin
          cnt_n = cnt + CNT_W'(1);
          sh_n  = sh >> 1;
          if (byte_end) begin
            cnt_n = '0;
            if (rep == PRE_CNT_W'(1)) st_n = S_OFLAG;
            else begin rep_n = rep - PRE_CNT_W'(1); sh_n = pre_byte; end
          end
        end
        S_OFLAG: begin
          cnt_n = cnt + CNT_W'(1);
          if (byte_end) begin
            cnt_n = '0;
            if (fifo_empty) st_n = no_crc ? S_CFLAG : S_FCS;
            else begin st_n = S_DATA; sh_n = fifo_data; last_n = fifo_last; end
          end
        end
        S_DATA: begin
          cnt_n = cnt + CNT_W'(1);
          sh_n  = sh >> 1;
          if (byte_end) begin
            cnt_n = '0;
            if (pay_done) st_n = no_crc ? S_CFLAG : S_FCS;
            else begin sh_n = fifo_data; last_n = fifo_last; end
          end
        end
        S_FCS: begin
          cnt_n = cnt + CNT_W'(1);
          if (fcs_end) begin cnt_n = '0; st_n = S_CFLAG; end
        end
        default: begin
          cnt_n = cnt + CNT_W'(1);
          if (byte_end) begin cnt_n = '0; st_n = S_IDLE; end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; last_q <= 1'b0; rep <= '0;
      tx_bit <= 1'b1; dtr_n <= 1'b1;
    end else begin
      dtr_n  <= ~dtr_req;
      tx_bit <= ev_run ? cur_bit : 1'b1;
      if (ev_kill) begin
        st <= S_IDLE; cnt <= '0;
      end else if (ev_run) begin
        st <= st_n; cnt <= cnt_n; sh <= sh_n; last_q <= last_n; rep <= rep_n;
      end
    end
  end

  hdlc_tx_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .preset  (ev_run & (st == S_OFLAG)),
    .absorb  (advance & (st == S_DATA)),
    .din     (sh[0]),
    .drain   (advance & (st == S_FCS)),
    .fcs_bit (fcs_bit)
  );

  hdlc_tx_stuff #(.RUN_MAX(5)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stuff_clr),
    .step      (stuff_step),
    .bit_in    (cur_bit),
    .stuff_due (stuff_due)
  );
endmodule

// File: rtl/hdlc_tx_flow_chk.sv
module hdlc_tx_flow_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       dma_mode,
  input logic       dtr_req,
  input logic       dtr_n,
  input logic       tx_bit,
  input logic       fifo_empty,
  input logic       fifo_pop,
  input logic       fifo_flush,
  input logic       ev_hold,
  input logic       ev_kill,
  input logic       st_idle,
  input logic       st_pre,
  input logic [2:0] st_code
);
  // R2
  dtr_low_chk: assert property (@(posedge clk) disable iff (!rst_n) dtr_req |=> !dtr_n);
  // R2
  dtr_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !dtr_req |=> dtr_n);
  // R3
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> tx_bit);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_hold |=> ($stable(st_code) && tx_bit));
  // R11
  cts_reset_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_kill |=> st_idle);
  // R9
  dma_no_pre_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_idle && dma_mode) |=> !st_pre);
  // R13
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_pop |-> !fifo_empty);
  // R11
  flush_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_flush |-> !fifo_pop);
endmodule

bind hdlc_tx_flow hdlc_tx_flow_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .dma_mode   (dma_mode),
  .dtr_req    (dtr_req),
  .dtr_n      (dtr_n),
  .tx_bit     (tx_bit),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .fifo_flush (fifo_flush),
  .ev_hold    (ev_hold),
  .ev_kill    (ev_kill),
  .st_idle    (st_idle),
  .st_pre     (st_pre),
  .st_code    (st_code)
);

// File: tb/hdlc_tx_flow_tb.sv
module hdlc_tx_flow_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, dma_mode = 0, pre_en = 0, no_crc = 0, auto_en = 0, dtr_req = 0, cts_n = 0;
  logic [7:0] pre_byte = 8'hAA, pre_count = 8'd0;
  logic fifo_empty = 1'b1, fifo_last = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_pop, fifo_flush, dtr_n, tx_bit;

  int total = 0, bad = 0, cyc = 0, hold_bad = 0;
  bit rec = 0;
  bit rx[$];
  logic [8:0] fq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_flow u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_mode(dma_mode), .pre_en(pre_en),
    .pre_byte(pre_byte), .pre_count(pre_count), .no_crc(no_crc), .auto_en(auto_en),
    .dtr_req(dtr_req), .cts_n(cts_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .dtr_n(dtr_n), .tx_bit(tx_bit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void refresh();
    fifo_empty = (fq.size() == 0);
    {fifo_last, fifo_data} = fifo_empty ? 9'h0 : fq[0];
  endfunction

  // queue model and line recorder, both sampled just after the edge
  always @(posedge clk) begin
    bit popped;
    popped = fifo_pop;
    #1;
    cyc++;
    if (popped && fq.size() > 0) void'(fq.pop_front());
    if (fifo_flush) fq.delete();
    refresh();
    if (rec) begin
      if (tx_en && cts_n) begin
        if (!tx_bit) hold_bad++;
      end else rx.push_back(tx_bit);
    end
  end

  initial begin
    wait (cyc > 150000);
    chk(1'b0, "R3", "watchdog expired", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic push(input logic [7:0] b[$], input bit mark_last);
    @(negedge clk);
    foreach (b[i]) fq.push_back({mark_last && (i == b.size() - 1), b[i]});
    refresh();
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] fcs_of(input logic [7:0] b[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[i]) begin
      c ^= {8'h00, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  // decode rx: leading ones, preamble bytes, flag, destuffed body, flag, ones
  task automatic parse(input logic [7:0] pay[$], input int exp_reps, input logic [7:0] pb,
                       input bit with_fcs, input string rreq);
    int i = 0, reps = 0, ones = 0;
    bit closed = 0, tail_ok = 1;
    bit db[$];
    logic [7:0] got[$];
    logic [7:0] exp_b[$];
    logic [15:0] f;
    while (i < rx.size() && rx[i]) i++;
    while (i + 8 <= rx.size()) begin
      logic [7:0] v;
      for (int k = 0; k < 8; k++) v[k] = rx[i+k];
      if (v != pb) break;
      reps++; i += 8;
    end
    chk(reps == exp_reps, rreq, "preamble repetitions", reps, exp_reps);
    begin
      logic [7:0] v = 8'h00;
      for (int k = 0; k < 8; k++) v[k] = (i + k < rx.size()) ? rx[i+k] : 1'b1;
      chk(v == 8'h7E, "R4", "opening flag", v, 8'h7E);
      i += 8;
    end
    while (i < rx.size() && !closed) begin
      bit b = rx[i];
      i++;
      if (ones == 5) begin
        if (!b) ones = 0;
        else begin
          repeat (6) if (db.size() > 0) void'(db.pop_back());
          chk(i < rx.size() && rx[i] == 1'b0, "R4", "closing flag tail", 0, 0);
          i++; closed = 1;
        end
      end else begin
        db.push_back(b);
        ones = b ? ones + 1 : 0;
      end
    end
    chk(closed, "R4", "closing flag found", closed, 1);
    while (i < rx.size()) begin
      if (!rx[i]) tail_ok = 0;
      i++;
    end
    chk(tail_ok, "R3", "mark idle after frame", tail_ok, 1);
    chk(db.size() % 8 == 0, "R5", "destuffed length byte aligned", db.size(), 0);
    for (int j = 0; j + 8 <= db.size(); j += 8) begin
      logic [7:0] v;
      for (int k = 0; k < 8; k++) v[k] = db[j+k];
      got.push_back(v);
    end
    exp_b = pay;
    if (with_fcs) begin
      f = fcs_of(pay);
      exp_b.push_back(f[7:0]);
      exp_b.push_back(f[15:8]);
    end
    chk(got.size() == exp_b.size(), with_fcs ? "R6" : "R7", "byte count", got.size(), exp_b.size());
    foreach (exp_b[j])
      if (j < got.size())
        chk(got[j] == exp_b[j], (j < pay.size()) ? "R5" : "R6", "frame byte", got[j], exp_b[j]);
  endtask

  task automatic send_frame(input logic [7:0] pay[$], input bit mark_last, input int reps);
    rx.delete(); rec = 1;
    push(pay, mark_last);
    waitc((pay.size() + reps + 6) * 12 + 30);
    rec = 0;
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    chk(dtr_n == 1'b1, "R1", "dtr_n in reset", dtr_n, 1);
    chk(fifo_pop == 1'b0, "R1", "fifo_pop in reset", fifo_pop, 0);
  endtask

  task automatic t_dtr();
    @(negedge clk); dtr_req = 1;
    @(posedge clk); #2;
    chk(dtr_n == 1'b0, "R2", "dtr_n after request", dtr_n, 0);
    @(negedge clk); dtr_req = 0;
    @(posedge clk); #2;
    chk(dtr_n == 1'b1, "R2", "dtr_n after release", dtr_n, 1);
  endtask

  task automatic t_off_then_on();
    logic [7:0] p[$] = '{8'h12, 8'h34};
    int ones_bad = 0, flush_seen = 0;
    @(negedge clk); tx_en = 0; auto_en = 1; cts_n = 1;
    push(p, 1);
    repeat (40) begin
      @(posedge clk); #2;
      if (!tx_bit) ones_bad++;
      if (fifo_flush) flush_seen++;
    end
    chk(ones_bad == 0, "R3", "line idle while disabled", ones_bad, 0);
    chk(flush_seen == 0, "R12", "no flush while disabled", flush_seen, 0);
    chk(fq.size() == 2, "R12", "queued bytes kept while disabled", fq.size(), 2);
    @(negedge clk); auto_en = 0; cts_n = 0; tx_en = 1;
    rx.delete(); rec = 1; waitc(100); rec = 0;
    parse(p, 0, 8'hAA, 1, "R8");
  endtask

  task automatic t_basic();
    logic [7:0] p[$] = '{8'hFF, 8'h7E, 8'h3E, 8'h01, 8'hF8};
    send_frame(p, 1, 0);
    parse(p, 0, 8'hAA, 1, "R8");
    chk(fq.size() == 0, "R13", "all bytes consumed", fq.size(), 0);
  endtask

  task automatic t_nocrc();
    logic [7:0] p[$] = '{8'hFF, 8'hFF, 8'h55};
    @(negedge clk); no_crc = 1;
    send_frame(p, 1, 0);
    parse(p, 0, 8'hAA, 0, "R8");
    @(negedge clk); no_crc = 0;
  endtask

  task automatic t_preamble();
    logic [7:0] p[$] = '{8'hC3, 8'h1F};
    @(negedge clk); pre_en = 1; pre_byte = 8'hAA; pre_count = 8'd3;
    send_frame(p, 1, 3);
    parse(p, 3, 8'hAA, 1, "R8");
    @(negedge clk); pre_byte = 8'h5A; pre_count = 8'd0;
    send_frame(p, 1, 0);
    parse(p, 0, 8'h5A, 1, "R8");
    @(negedge clk); pre_en = 0;
  endtask

  task automatic t_dma();
    logic [7:0] p[$] = '{8'h0F};
    @(negedge clk); pre_en = 1; dma_mode = 1; pre_byte = 8'h5A; pre_count = 8'd4;
    send_frame(p, 1, 4);
    parse(p, 0, 8'h5A, 1, "R9");
    @(negedge clk); pre_en = 0; dma_mode = 0; pre_count = 8'd0;
  endtask

  task automatic t_hold();
    logic [7:0] p[$] = '{8'h11, 8'hFF, 8'h22, 8'hFC, 8'h33, 8'h44};
    int flush_seen = 0, sz;
    @(negedge clk); auto_en = 0; hold_bad = 0;
    rx.delete(); rec = 1;
    push(p, 1);
    waitc(30);
    sz = fq.size();
    cts_n = 1;
    repeat (25) begin
      @(posedge clk); #2;
      if (fifo_flush) flush_seen++;
    end
    chk(flush_seen == 0, "R10", "no flush in hold", flush_seen, 0);
    chk(fq.size() == sz, "R10", "queue untouched in hold", fq.size(), sz);
    chk(hold_bad == 0, "R10", "mark idle in hold", hold_bad, 0);
    @(negedge clk); cts_n = 0;
    waitc(150); rec = 0;
    parse(p, 0, 8'hAA, 1, "R10");
  endtask

  task automatic t_flush();
    logic [7:0] p[$] = '{8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87, 8'h88};
    logic [7:0] q[$] = '{8'hA5, 8'hFF};
    int flush_seen = 0, ones_bad = 0;
    @(negedge clk); auto_en = 1; hold_bad = 0;
    push(p, 1);
    waitc(35);
    cts_n = 1;
    repeat (10) begin
      @(posedge clk); #2;
      if (fifo_flush) flush_seen++;
      if (!tx_bit) ones_bad++;
    end
    chk(flush_seen == 10, "R11", "flush asserted while CTS lost", flush_seen, 10);
    chk(ones_bad == 0, "R11", "mark idle while CTS lost", ones_bad, 0);
    chk(fq.size() == 0, "R11", "queue emptied", fq.size(), 0);
    @(negedge clk); cts_n = 0;
    rx.delete(); rec = 1; waitc(60); rec = 0;
    ones_bad = 0;
    foreach (rx[i]) if (!rx[i]) ones_bad++;
    chk(ones_bad == 0, "R11", "no stale frame after CTS back", ones_bad, 0);
    send_frame(q, 1, 0);
    parse(q, 0, 8'hAA, 1, "R11");
    @(negedge clk); auto_en = 0;
  endtask

  task automatic t_underrun();
    logic [7:0] p[$] = '{8'h3C, 8'hE7};
    send_frame(p, 0, 0);
    parse(p, 0, 8'hAA, 1, "R13");
  endtask

  initial begin
    t_reset();
    waitc(3);
    @(negedge clk); rst_n = 1;
    waitc(2);
    t_dtr();
    t_off_then_on();
    t_basic();
    t_nocrc();
    t_preamble();
    t_dma();
    t_hold();
    t_flush();
    t_underrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule